// File: doc/BRIEF.md
# I2C Master Clock and Bus-Condition Generator

This block is the timing half of an I2C master. It shapes the SCL waveform from programmable clock counts and frames the bus with START, repeated START and STOP conditions. A byte engine above it hands over one bit slot at a time through a valid/ready command port. The block drives SDA for that slot and returns a sample strobe carrying the line level it read, plus a strobe when the slot's clock pulse has ended.

Both lines are driven open-drain style. Each pin has an output value and an output enable. A per-pin direct control can exchange the two signals for pad cells that want them the other way round. The low period, the high period and the repeated-START setup delay are separate counts. The generator holds in the high-edge state until the SCL line is really seen high, so a slave can stretch the clock. A 3-bit state code is exported as status. One-cycle event pulses mark each emitted START and each finished STOP.

Top module: `scl_timing_gen`

## Requirements
- R1: State codes are 0 idle, 1 start, 2 low edge, 3 low, 4 high edge, 5 high, 6 stop. After reset the state is 0, both lines are released (with direct controls at 1: `scl_o`=`sda_o`=1 and `scl_oe`=`sda_oe`=0) and every strobe is 0.
- R2: Command codes are 0 START, 1 BIT, 2 STOP and 3 no-op. A START accepted in idle pulls SDA, enters state 1 and pulses `start_evt` in the cycle after acceptance. SCL is pulled `high_cnt`+1 cycles later, in state 2.
- R3: BIT, STOP and repeated START are accepted only in state 2. The cycle after acceptance enters state 3 with SDA set for the slot: for BIT, 1 releases and 0 pulls. SCL stays pulled for `low_cnt`+2 cycles in all (state 2 plus state 3).
- R4: After release, state 4 holds until `scl_in` is sampled high, for S extra cycles of stretching. Then state 5 lasts `high_cnt`+1 cycles, so SCL is released for `high_cnt`+2+S cycles of a BIT slot. SDA does not change in state 5.
- R5: With `sample_low`=1, `smp_strobe` pulses in the first state-4 cycle and `smp_bit` holds the SDA level of the last state-3 cycle. With `sample_low`=0, it pulses in the first state-5 cycle with the level of the last state-4 cycle. BIT slots only.
- R6: `bit_done` pulses for one cycle in the first state-2 cycle after a BIT slot's state 5.
- R7: A repeated START releases SDA in state 3. SDA is pulled `rs_setup`+2+S cycles after SCL is released, in state 1, with `start_evt`. SCL is pulled `high_cnt`+1 cycles after that.
- R8: A STOP pulls SDA in state 3 and then releases SCL. It passes through state 6 and releases SDA `high_cnt`+2+S cycles after the SCL release. In that same cycle it enters state 0 and pulses `stop_evt`.
- R9: In idle a BIT, STOP or no-op command is consumed with no effect. In state 2 a no-op is consumed and the block waits for the next command.
- R10: With `scl_direct`=0 the SCL output value and output enable exchange roles. `sda_direct` does the same for SDA, and the two pins are independent.
- R11: Each strobe and event is one cycle wide, and no event occurs other than those listed above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| low_cnt | input | CNT_W | SCL low period count |
| high_cnt | input | CNT_W | SCL high period count, also START hold and STOP setup |
| rs_setup | input | RS_W | Repeated-START setup count |
| sample_low | input | 1 | 1: sample while SCL low, 0: sample while SCL high |
| scl_direct | input | 1 | 1: normal SCL pins, 0: swap value and enable |
| sda_direct | input | 1 | 1: normal SDA pins, 0: swap value and enable |
| cmd_valid | input | 1 | Command present |
| cmd | input | 2 | 0 START, 1 BIT, 2 STOP, 3 no-op |
| cmd_bit | input | 1 | Data bit for a BIT command |
| cmd_ready | output | 1 | Command can be taken this cycle |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| scl_o | output | 1 | SCL output value |
| scl_oe | output | 1 | SCL output enable |
| sda_o | output | 1 | SDA output value |
| sda_oe | output | 1 | SDA output enable |
| smp_strobe | output | 1 | Sample taken this cycle |
| smp_bit | output | 1 | Sampled SDA level |
| bit_done | output | 1 | BIT slot finished |
| start_evt | output | 1 | START or repeated START emitted |
| stop_evt | output | 1 | STOP completed |
| state | output | 3 | Generator state code |

## Verification
Every result is due at a fixed offset from the START that opens its transaction. For each slot the offset is the low and high counts plus 2, plus the setup count for a repeated START, plus the stretch cycles the bench itself inserts on the SCL line. The driver computes each expected edge, event, sampled bit and state code with its offset before it issues the commands. A monitor running on the falling clock edge pops them in order and compares the pin-level edges and strobes against them. Any event with nothing queued is a miscompare, which covers the ignored commands and the one-cycle pulse widths.

// File: rtl/scl_timing_gen.sv
`timescale 1ns/1ps
module scl_timing_gen #(
  parameter int CNT_W = 16,
  parameter int RS_W  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] low_cnt,
  input  logic [CNT_W-1:0] high_cnt,
  input  logic [RS_W-1:0]  rs_setup,
  input  logic             sample_low,
  input  logic             scl_direct,
  input  logic             sda_direct,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd,
  input  logic             cmd_bit,
  output logic             cmd_ready,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_o,
  output logic             scl_oe,
  output logic             sda_o,
  output logic             sda_oe,
  output logic             smp_strobe,
  output logic             smp_bit,
  output logic             bit_done,
  output logic             start_evt,
  output logic             stop_evt,
  output logic [2:0]       state
);
  localparam logic [2:0] S_IDLE = 3'd0, S_START = 3'd1, S_LOW_EDGE = 3'd2, S_LOW = 3'd3,
                         S_HIGH_EDGE = 3'd4, S_HIGH = 3'd5, S_STOP = 3'd6;
  localparam logic [1:0] C_START = 2'd0, C_BIT = 2'd1, C_STOP = 2'd2, C_NOP = 2'd3;
  localparam logic [1:0] K_BIT = 2'd0, K_STOP = 2'd1, K_RSTART = 2'd2;

  logic [2:0]       st;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       slot;
  logic             setup_ph;
  logic             sda_pull;

  wire scl_pull = (st == S_LOW_EDGE) || (st == S_LOW);
  wire expired  = (cnt == '0);
  wire take     = cmd_valid && cmd_ready;

  assign cmd_ready = (st == S_IDLE) || (st == S_LOW_EDGE);
  assign state     = st;
  assign scl_o     = scl_direct ? ~scl_pull : scl_pull;
  assign scl_oe    = scl_direct ? scl_pull : ~scl_pull;
  assign sda_o     = sda_direct ? ~sda_pull : sda_pull;
  assign sda_oe    = sda_direct ? sda_pull : ~sda_pull;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      slot       <= K_BIT;
      setup_ph   <= 1'b0;
      sda_pull   <= 1'b0;
      smp_strobe <= 1'b0;
      smp_bit    <= 1'b0;
      bit_done   <= 1'b0;
      start_evt  <= 1'b0;
      stop_evt   <= 1'b0;
    end else begin
      smp_strobe <= 1'b0;
      bit_done   <= 1'b0;
      start_evt  <= 1'b0;
      stop_evt   <= 1'b0;
      if (!expired) cnt <= cnt - 1'b1;
      case (st)
        S_IDLE: if (take && cmd == C_START) begin
          st        <= S_START;
          setup_ph  <= 1'b0;
          sda_pull  <= 1'b1;
          start_evt <= 1'b1;
          cnt       <= high_cnt;
        end
        S_START: if (expired) begin
          if (setup_ph) begin
            setup_ph  <= 1'b0;
            sda_pull  <= 1'b1;
            start_evt <= 1'b1;
            cnt       <= high_cnt;
          end else begin
            st <= S_LOW_EDGE;
          end
        end
        S_LOW_EDGE: if (take && cmd != C_NOP) begin
          st  <= S_LOW;
          cnt <= low_cnt;
          if (cmd == C_BIT) begin
            slot     <= K_BIT;
            sda_pull <= ~cmd_bit;
          end else if (cmd == C_STOP) begin
            slot     <= K_STOP;
            sda_pull <= 1'b1;
          end else begin
            slot     <= K_RSTART;
            sda_pull <= 1'b0;
          end
        end
        S_LOW: if (expired) begin
          st <= S_HIGH_EDGE;
          if (sample_low && slot == K_BIT) begin
            smp_strobe <= 1'b1;
            smp_bit    <= sda_in;
          end
        end
        S_HIGH_EDGE: if (scl_in) begin
          if (slot == K_STOP) begin
            st  <= S_STOP;
            cnt <= high_cnt;
          end else if (slot == K_RSTART) begin
            st       <= S_START;
            setup_ph <= 1'b1;
            cnt      <= CNT_W'(rs_setup);
          end else begin
            st  <= S_HIGH;
            cnt <= high_cnt;
            if (!sample_low) begin
              smp_strobe <= 1'b1;
              smp_bit    <= sda_in;
            end
          end
        end
        S_HIGH: if (expired) begin
          st       <= S_LOW_EDGE;
          bit_done <= 1'b1;
        end
        S_STOP: if (expired) begin
          st       <= S_IDLE;
          sda_pull <= 1'b0;
          stop_evt <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_edge_to_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOW && $past(st) != S_LOW) |-> $past(st) == S_LOW_EDGE)
    else $error("low phase entered from a state other than low edge");

  p_wait_line_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HIGH && $past(st) != S_HIGH) |-> $past(scl_in))
    else $error("high count started before SCL was seen high");

  p_sda_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HIGH && $past(st) == S_HIGH) |-> $stable(sda_pull))
    else $error("SDA moved while SCL high in a data slot");

  p_start_cond_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |-> (st == S_START && sda_pull && !scl_pull))
    else $error("start event without SDA low under released SCL");

  p_stop_cond_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |-> (st == S_IDLE && $past(st) == S_STOP && !sda_pull))
    else $error("stop event not at the end of the stop state");

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_done |=> !bit_done)
    else $error("bit done wider than one cycle");

  p_strobe_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    smp_strobe |=> !smp_strobe)
    else $error("sample strobe wider than one cycle");
endmodule

// File: tb/scl_timing_gen_bench.sv
`timescale 1ns/1ps
module scl_timing_gen_bench;
  localparam int K_SCLF = 0, K_SCLR = 1, K_SDAF = 2, K_SDAR = 3,
                 K_ST = 4, K_SP = 5, K_SMP = 6, K_DONE = 7;
  localparam logic [1:0] C_START = 2'd0, C_BIT = 2'd1, C_STOP = 2'd2, C_NOP = 2'd3;

  typedef struct {
    int kind; logic dat; int at; logic [2:0] st; bit anchor; string req;
  } item_t;
  typedef struct { logic [1:0] c; logic b; logic a; int s; } slot_t;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [15:0] low_cnt = 16'd3, high_cnt = 16'd2;
  logic [9:0]  rs_setup = 10'd4;
  logic        sample_low = 1'b0, scl_direct = 1'b1, sda_direct = 1'b1;
  logic        cmd_valid = 1'b0, cmd_bit = 1'b0;
  logic [1:0]  cmd = C_NOP;
  logic        cmd_ready, scl_in, sda_in, scl_o, scl_oe, sda_o, sda_oe;
  logic        smp_strobe, smp_bit, bit_done, start_evt, stop_evt;
  logic [2:0]  state;

  logic hold = 1'b0, slave_pull = 1'b0;
  int   stretch_left = 0;

  wire scl_pull_pin = scl_direct ? (scl_oe & ~scl_o) : (scl_o & ~scl_oe);
  wire sda_pull_pin = sda_direct ? (sda_oe & ~sda_o) : (sda_o & ~sda_oe);
  assign scl_in = ~scl_pull_pin & ~hold;
  assign sda_in = ~sda_pull_pin & ~slave_pull;

  scl_timing_gen u_scl_timing_gen (
    .clk(clk), .rst_n(rst_n), .low_cnt(low_cnt), .high_cnt(high_cnt), .rs_setup(rs_setup),
    .sample_low(sample_low), .scl_direct(scl_direct), .sda_direct(sda_direct),
    .cmd_valid(cmd_valid), .cmd(cmd), .cmd_bit(cmd_bit), .cmd_ready(cmd_ready),
    .scl_in(scl_in), .sda_in(sda_in), .scl_o(scl_o), .scl_oe(scl_oe),
    .sda_o(sda_o), .sda_oe(sda_oe), .smp_strobe(smp_strobe), .smp_bit(smp_bit),
    .bit_done(bit_done), .start_evt(start_evt), .stop_evt(stop_evt), .state(state));

  item_t expq[$];
  slot_t slots[$];
  int vectors = 0, miss = 0, cyc = 0, anchor = 0;
  bit mon_on = 1'b0, fin = 1'b0;
  logic p_scl = 1'b0, p_sda = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (scl_pull_pin == 1'b0 && stretch_left > 0) begin
      hold <= 1'b1;
      stretch_left <= stretch_left - 1;
    end else begin
      hold <= 1'b0;
    end
  end

  task automatic push(int kind, logic dat, int at, logic [2:0] st, bit anc, string req);
    item_t it;
    it.kind = kind; it.dat = dat; it.at = at; it.st = st; it.anchor = anc; it.req = req;
    expq.push_back(it);
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      miss++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic observe(int kind, logic dat);
    item_t it;
    vectors++;
    if (expq.size() == 0) begin
      miss++;
      $display("FAIL R9 R11 unexpected event: actual kind %0d at cycle %0d, expected none", kind, cyc);
      return;
    end
    it = expq.pop_front();
    if (it.anchor) anchor = cyc;
    if (kind != it.kind || (kind == K_SMP && dat !== it.dat) || state !== it.st ||
        (!it.anchor && (cyc - anchor) != it.at)) begin
      miss++;
      $display("FAIL %s: actual kind=%0d data=%0d state=%0d offset=%0d, expected kind=%0d data=%0d state=%0d offset=%0d",
               it.req, kind, dat, state, cyc - anchor, it.kind, it.dat, it.st, it.at);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      if (scl_pull_pin && !p_scl) observe(K_SCLF, 1'b0);
      if (!scl_pull_pin && p_scl) observe(K_SCLR, 1'b0);
      if (sda_pull_pin && !p_sda) observe(K_SDAF, 1'b0);
      if (!sda_pull_pin && p_sda) observe(K_SDAR, 1'b0);
      if (start_evt)  observe(K_ST, 1'b0);
      if (stop_evt)   observe(K_SP, 1'b0);
      if (smp_strobe) observe(K_SMP, smp_bit);
      if (bit_done)   observe(K_DONE, 1'b0);
    end
    p_scl <= scl_pull_pin;
    p_sda <= sda_pull_pin;
  end

  task automatic issue(logic [1:0] c, logic b, logic a, int s);
    @(negedge clk);
    cmd_valid = 1'b1; cmd = c; cmd_bit = b;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0; cmd = C_NOP; slave_pull = a; stretch_left = s;
  endtask

  task automatic add(logic [1:0] c, logic b, logic a, int s);
    slot_t sl;
    sl.c = c; sl.b = b; sl.a = a; sl.s = s;
    slots.push_back(sl);
  endtask

  task automatic run_txn();
    int L, H, R, t, f, s;
    logic pv, np;
    L = int'(low_cnt); H = int'(high_cnt); R = int'(rs_setup);
    push(K_SDAF, 1'b0, 0, 3'd1, 1'b1, "R2");
    push(K_ST, 1'b0, 0, 3'd1, 1'b0, "R2");
    t = H + 1;
    push(K_SCLF, 1'b0, t, 3'd2, 1'b0, "R2");
    pv = 1'b1;
    foreach (slots[i]) begin
      f = t; s = slots[i].s;
      case (slots[i].c)
        C_NOP: t = t + 2;
        C_BIT: begin
          np = ~slots[i].b;
          if (np != pv) push(np ? K_SDAF : K_SDAR, 1'b0, f + 1, 3'd3, 1'b0, "R3");
          pv = np;
          push(K_SCLR, 1'b0, f + L + 2, 3'd4, 1'b0, "R3");
          if (sample_low) push(K_SMP, slots[i].b & ~slots[i].a, f + L + 2, 3'd4, 1'b0, "R5");
          else            push(K_SMP, slots[i].b & ~slots[i].a, f + L + 3 + s, 3'd5, 1'b0, "R5");
          t = f + L + H + 4 + s;
          push(K_SCLF, 1'b0, t, 3'd2, 1'b0, "R4");
          push(K_DONE, 1'b0, t, 3'd2, 1'b0, "R6");
        end
        C_STOP: begin
          if (!pv) push(K_SDAF, 1'b0, f + 1, 3'd3, 1'b0, "R8");
          pv = 1'b1;
          push(K_SCLR, 1'b0, f + L + 2, 3'd4, 1'b0, "R8");
          push(K_SDAR, 1'b0, f + L + 4 + s + H, 3'd0, 1'b0, "R8");
          push(K_SP, 1'b0, f + L + 4 + s + H, 3'd0, 1'b0, "R8");
        end
        default: begin
          if (pv) push(K_SDAR, 1'b0, f + 1, 3'd3, 1'b0, "R7");
          push(K_SCLR, 1'b0, f + L + 2, 3'd4, 1'b0, "R7");
          push(K_SDAF, 1'b0, f + L + 4 + s + R, 3'd1, 1'b0, "R7");
          push(K_ST, 1'b0, f + L + 4 + s + R, 3'd1, 1'b0, "R7");
          t = f + L + 5 + s + R + H;
          push(K_SCLF, 1'b0, t, 3'd2, 1'b0, "R7");
          pv = 1'b1;
        end
      endcase
    end
    issue(C_START, 1'b0, 1'b0, 0);
    foreach (slots[i]) issue(slots[i].c, slots[i].b, slots[i].a, slots[i].s);
    for (int k = 0; k < 3000 && expq.size() != 0; k++) @(negedge clk);
    repeat (4) @(negedge clk);
    check(expq.size() == 0, "R11 pending events", expq.size(), 0);
    expq.delete();
    slots.delete();
    slave_pull = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      vectors++; miss++;
      $display("FAIL R1 watchdog: actual still running, expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(state == 3'd0, "R1 reset state", state, 0);
    check({scl_o, scl_oe, sda_o, sda_oe} == 4'b1010, "R1 reset pins", {scl_o, scl_oe, sda_o, sda_oe}, 4'b1010);
    check({smp_strobe, bit_done, start_evt, stop_evt} == 4'b0, "R1 reset strobes",
          {smp_strobe, bit_done, start_evt, stop_evt}, 0);
    mon_on = 1'b1;

    // R9 commands other than START are ignored in idle
    issue(C_STOP, 1'b0, 1'b0, 0);
    issue(C_BIT, 1'b0, 1'b0, 0);
    issue(C_NOP, 1'b0, 1'b0, 0);
    repeat (6) @(negedge clk);
    check(state == 3'd0, "R9 idle after ignored commands", state, 0);
    check(scl_pull_pin == 1'b0 && sda_pull_pin == 1'b0, "R9 lines released", {scl_pull_pin, sda_pull_pin}, 0);

    // sampling while SCL high, plain bits, ack on one bit
    low_cnt = 16'd3; high_cnt = 16'd2; rs_setup = 10'd4; sample_low = 1'b0;
    add(C_BIT, 1'b1, 1'b0, 0); add(C_BIT, 1'b0, 1'b0, 0); add(C_BIT, 1'b1, 1'b1, 0);
    add(C_STOP, 1'b0, 1'b0, 0);
    run_txn();

    // sampling while SCL low, stretching, no-op in low edge (R9), repeated START
    low_cnt = 16'd2; high_cnt = 16'd4; rs_setup = 10'd5; sample_low = 1'b1;
    add(C_BIT, 1'b0, 1'b0, 0); add(C_BIT, 1'b1, 1'b1, 0); add(C_BIT, 1'b1, 1'b0, 3);
    add(C_NOP, 1'b0, 1'b0, 0);
    add(C_START, 1'b0, 1'b0, 2); add(C_BIT, 1'b1, 1'b0, 0); add(C_STOP, 1'b0, 1'b0, 2);
    run_txn();

    // stretching under high sampling, zero counts, repeated START with setup 0
    low_cnt = 16'd0; high_cnt = 16'd0; rs_setup = 10'd0; sample_low = 1'b0;
    add(C_BIT, 1'b0, 1'b0, 4); add(C_START, 1'b0, 1'b0, 0); add(C_BIT, 1'b1, 1'b0, 1);
    add(C_STOP, 1'b0, 1'b0, 0);
    run_txn();

    // R10 swapped SCL pins
    scl_direct = 1'b0;
    @(negedge clk);
    check(scl_o == 1'b0 && scl_oe == 1'b1, "R10 SCL swapped idle", {scl_o, scl_oe}, 2'b01);
    check(sda_o == 1'b1 && sda_oe == 1'b0, "R10 SDA unaffected", {sda_o, sda_oe}, 2'b10);
    low_cnt = 16'd1; high_cnt = 16'd1; rs_setup = 10'd2;
    add(C_BIT, 1'b0, 1'b0, 0); add(C_BIT, 1'b1, 1'b1, 0); add(C_STOP, 1'b0, 1'b0, 0);
    run_txn();

    // R10 both pins swapped
    sda_direct = 1'b0;
    @(negedge clk);
    check(sda_o == 1'b0 && sda_oe == 1'b1, "R10 SDA swapped idle", {sda_o, sda_oe}, 2'b01);
    add(C_BIT, 1'b1, 1'b0, 1); add(C_START, 1'b0, 1'b0, 0); add(C_BIT, 1'b0, 1'b0, 0);
    add(C_STOP, 1'b0, 1'b0, 1);
    run_txn();
    scl_direct = 1'b1; sda_direct = 1'b1;
    @(negedge clk);
    check(state == 3'd0, "R8 idle at end", state, 0);

    fin = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  end
endmodule